// File: doc/BRIEF.md
# Threshold-Triggered DMA Burst Requester

This block sits beside one DMA channel's FIFO. It watches the FIFO occupancy and raises a request to the bus master once enough work has built up for a burst. While the FIFO is drained to memory, that work is the number of valid Dwords held. While the FIFO is filled from memory, it is the number of free Dword slots. Audio channels use a smaller set of trigger levels than video channels. Software programs two codes through a small configuration register: the burst size and the trigger level.

The block is a three-state machine. In `ST_IDLE` it waits. On `T_TRIGGER` (threshold met) it moves to `ST_REQ`, latches the burst code and holds the request. On `T_GRANT` (grant seen) it moves to `ST_BURST` and loads a Dword counter with the burst length. In `ST_BURST` the counter drops by one for each accepted Dword. The machine returns to `ST_IDLE` either on `T_DONE`, when the last Dword is accepted, or on `T_STARVE`, when the FIFO runs out of data (drain mode) or out of room (fill mode). On `T_STARVE` the counter is cleared. The bus protocol, the arbitration between channels and the FIFO storage lie outside the block.

Top module: `burst_req_ctrl`

## Requirements
- R1: The burst code selects a length of 2^code Dwords, from 1 for code 0 to 128 for code 7. The length is shown on `burst_len` from the cycle the request rises.
- R2: On a video channel (`chan_audio`=0), threshold codes 0, 1, 2 and 3 stand for 4, 8, 16 and 32 Dwords.
- R3: On an audio channel (`chan_audio`=1), threshold codes 0, 1, 2 and 3 stand for 1, 4, 8 and 16 Dwords.
- R4: With `dir_rd`=0 (FIFO to memory) the compared count is `fifo_level`. With `dir_rd`=1 (memory to FIFO) it is DEPTH minus `fifo_level`.
- R5: The threshold is met when the count is greater than or equal to the threshold value. In `ST_IDLE`, a met threshold raises `req` at the next clock edge. A count one below the threshold leaves `req` low.
- R6: A write with `cfg_we` high stores `cfg_wdata[4:2]` as the burst code and `cfg_wdata[1:0]` as the threshold code. `cfg_rdata` returns both codes in the same positions at once.
- R7: `req` stays high, whatever the FIFO count does, until a cycle with `grant` high. After that cycle `req` is low and `burst_active` is high.
- R8: The grant loads `dw_count` with the burst length. Each cycle in the burst with `dw_accept` high lowers it by one. Accepting the last Dword ends the burst.
- R9: In the burst, a compared count of zero ends the burst at the next edge and clears `dw_count` to zero. This holds even when the same cycle also accepts the last Dword.
- R10: A configuration write during a request or a burst changes neither `burst_len` nor the running count. The new burst code applies from the next request.
- R11: After reset `req` and `burst_active` are low, `dw_count` is zero and both codes are zero.
- R12: Outside a burst, `dw_count` stays zero, and `dw_accept` and `grant` have no effect while the threshold is unmet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | [4:2] burst code, [1:0] threshold code |
| cfg_rdata | output | 5 | Stored codes, same layout |
| dir_rd | input | 1 | 1 = memory to FIFO, 0 = FIFO to memory |
| chan_audio | input | 1 | 1 = audio threshold table, 0 = video |
| fifo_level | input | LEVEL_W | Valid Dwords held in the FIFO |
| grant | input | 1 | Bus master grant |
| dw_accept | input | 1 | One Dword transferred this cycle |
| req | output | 1 | Burst request |
| burst_active | output | 1 | Burst in progress |
| burst_len | output | 8 | Latched burst length in Dwords |
| dw_count | output | 8 | Dwords left in the current burst |

## Verification
Two ways of ending a burst can fall in the same cycle: the last Dword is accepted (`T_DONE`) while the FIFO count reaches zero (`T_STARVE`). The bench provokes this by driving the final `dw_accept` together with a `fifo_level` that leaves nothing to move. It then requires the machine to be idle with a zero count, and requires that no request follows in the next cycle. The bench also writes the configuration in the middle of a burst. It judges that the latched length and the running count are untouched, and that the next request carries the new length.

// File: rtl/brq_pkg.sv
package brq_pkg;

    localparam int BCODE_W = 3;
    localparam int TCODE_W = 2;
    localparam int CFG_W   = BCODE_W + TCODE_W;
    localparam int MAX_LEN = 1 << ((1 << BCODE_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam int THR_W   = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_BURST = 2'd2
    } brq_state_e;

    // Trigger level in Dwords for a class and code.
    function automatic logic [THR_W-1:0] thr_dwords(input logic audio,
                                                    input logic [TCODE_W-1:0] code);
        logic [THR_W-1:0] v;
        unique case ({audio, code})
            3'b000:  v = 6'd4;
            3'b001:  v = 6'd8;
            3'b010:  v = 6'd16;
            3'b011:  v = 6'd32;
            3'b100:  v = 6'd1;
            3'b101:  v = 6'd4;
            3'b110:  v = 6'd8;
            default: v = 6'd16;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/brq_cfg.sv
module brq_cfg
    import brq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [CFG_W-1:0]   wdata,
    output logic [BCODE_W-1:0] burst_code,
    output logic [TCODE_W-1:0] thr_code
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_code <= '0;
            thr_code   <= '0;
        end else if (we) begin
            burst_code <= wdata[CFG_W-1:TCODE_W];
            thr_code   <= wdata[TCODE_W-1:0];
        end
    end

endmodule

// File: rtl/brq_thresh.sv
module brq_thresh
    import brq_pkg::*;
#(
    parameter  int DEPTH   = 64,
    localparam int LEVEL_W = $clog2(DEPTH + 1),
    localparam int CMP_W   = (LEVEL_W > THR_W) ? LEVEL_W : THR_W
) (
    input  logic [LEVEL_W-1:0] level,
    input  logic               dir_rd,
    input  logic               audio,
    input  logic [TCODE_W-1:0] thr_code,
    output logic               met,
    output logic               avail_zero
);

    logic [LEVEL_W-1:0] avail;
    logic [THR_W-1:0]   thr;
    logic [CMP_W-1:0]   avail_ext;
    logic [CMP_W-1:0]   thr_ext;

    always_comb begin
        // drain mode counts held data, fill mode counts free slots
        avail      = dir_rd ? (LEVEL_W'(DEPTH) - level) : level;
        thr        = thr_dwords(audio, thr_code);
        avail_ext  = CMP_W'(avail);
        thr_ext    = CMP_W'(thr);
        met        = (avail_ext >= thr_ext);
        avail_zero = (avail == '0);
    end

endmodule

// File: rtl/brq_counter.sv
module brq_counter
    import brq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/burst_req_ctrl.sv
module burst_req_ctrl
    import brq_pkg::*;
#(
    parameter  int DEPTH   = 64,
    localparam int LEVEL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic               dir_rd,
    input  logic               chan_audio,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               grant,
    input  logic               dw_accept,
    output logic               req,
    output logic               burst_active,
    output logic [CNT_W-1:0]   burst_len,
    output logic [CNT_W-1:0]   dw_count
);

    brq_state_e         state_q, state_d;
    logic [BCODE_W-1:0] burst_code;
    logic [TCODE_W-1:0] thr_code;
    logic [BCODE_W-1:0] act_code_q;
    logic               met, avail_zero;
    logic               t_trigger, t_grant, t_done, t_starve;

    brq_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .wdata      (cfg_wdata),
        .burst_code (burst_code),
        .thr_code   (thr_code)
    );

    brq_thresh #(.DEPTH(DEPTH)) u_thresh (
        .level      (fifo_level),
        .dir_rd     (dir_rd),
        .audio      (chan_audio),
        .thr_code   (thr_code),
        .met        (met),
        .avail_zero (avail_zero)
    );

    // transition conditions
    always_comb begin
        t_trigger = (state_q == ST_IDLE)  && met;
        t_grant   = (state_q == ST_REQ)   && grant;
        t_done    = (state_q == ST_BURST) && dw_accept && (dw_count == CNT_W'(1));
        t_starve  = (state_q == ST_BURST) && avail_zero;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            act_code_q <= '0;
        end else begin
            state_q <= state_d;
            if (t_trigger) begin
                act_code_q <= burst_code;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (t_trigger)           state_d = ST_REQ;
            ST_REQ:   if (t_grant)             state_d = ST_BURST;
            ST_BURST: if (t_done || t_starve)  state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    brq_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (t_starve),
        .load     (t_grant),
        .load_val (burst_len),
        .dec      ((state_q == ST_BURST) && dw_accept),
        .cnt      (dw_count)
    );

    // outputs
    always_comb begin
        req          = (state_q == ST_REQ);
        burst_active = (state_q == ST_BURST);
        burst_len    = CNT_W'(1) << act_code_q;
        cfg_rdata    = {burst_code, thr_code};
    end

endmodule

// File: rtl/brq_checker.sv
module brq_checker
    import brq_pkg::*;
#(
    parameter  int DEPTH   = 64,
    localparam int LEVEL_W = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CFG_W-1:0]   cfg_rdata,
    input logic               dir_rd,
    input logic               chan_audio,
    input logic [LEVEL_W-1:0] fifo_level,
    input logic               grant,
    input logic               dw_accept,
    input logic               req,
    input logic               burst_active,
    input logic [CNT_W-1:0]   burst_len,
    input logic [CNT_W-1:0]   dw_count
);

    int unsigned cnt_avail;
    int unsigned cnt_thr;

    always_comb begin
        cnt_avail = dir_rd ? (DEPTH - int'(fifo_level)) : int'(fifo_level);
        cnt_thr   = int'(thr_dwords(chan_audio, cfg_rdata[TCODE_W-1:0]));
    end

    assert_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !burst_active && (cnt_avail >= cnt_thr)) |=> req);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !grant) |=> req);

    assert_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && grant) |=> (!req && burst_active));

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && grant) |=> (dw_count == burst_len));

    assert_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && dw_accept && (dw_count > 1) && (cnt_avail != 0))
        |=> (burst_active && (dw_count == $past(dw_count) - 1)));

    assert_starve_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && (cnt_avail == 0)) |=> (!burst_active && (dw_count == 0)));

    assert_len_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |-> $stable(burst_len));

    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |-> (dw_count == 0));

endmodule

bind burst_req_ctrl brq_checker #(.DEPTH(DEPTH)) u_brq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rdata    (cfg_rdata),
    .dir_rd       (dir_rd),
    .chan_audio   (chan_audio),
    .fifo_level   (fifo_level),
    .grant        (grant),
    .dw_accept    (dw_accept),
    .req          (req),
    .burst_active (burst_active),
    .burst_len    (burst_len),
    .dw_count     (dw_count)
);

// File: tb/test_burst_req_ctrl.sv
`timescale 1ns/1ps
module test_burst_req_ctrl;

    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic [4:0] cfg_rdata;
    logic       dir_rd = 1'b0;
    logic       chan_audio = 1'b0;
    logic [6:0] fifo_level = '0;
    logic       grant = 1'b0;
    logic       dw_accept = 1'b0;
    logic       req, burst_active;
    logic [7:0] burst_len, dw_count;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_req_ctrl #(.DEPTH(DEPTH)) i_burst_req_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dir_rd(dir_rd), .chan_audio(chan_audio),
        .fifo_level(fifo_level), .grant(grant), .dw_accept(dw_accept),
        .req(req), .burst_active(burst_active), .burst_len(burst_len),
        .dw_count(dw_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_avail(input int n);
        fifo_level = dir_rd ? 7'(DEPTH - n) : 7'(n);
    endtask

    task automatic cfg_write(input int b, input int t);
        cfg_we    = 1'b1;
        cfg_wdata = {3'(b), 2'(t)};
        tick();
        cfg_we    = 1'b0;
    endtask

    function automatic int exp_thr(input int audio, input int code);
        if (audio != 0) return (code == 0) ? 1 : (2 << code);
        return 4 << code;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11 req", int'(req), 0);
        chk("R11 active", int'(burst_active), 0);
        chk("R11 count", int'(dw_count), 0);
        chk("R11 codes", int'(cfg_rdata), 0);
        rst_n = 1'b1;
        tick();
        chk("R11 req after release", int'(req), 0);

        // R12 grant and accept with the threshold unmet
        grant = 1'b1; dw_accept = 1'b1;
        tick(); tick();
        grant = 1'b0; dw_accept = 1'b0;
        chk("R12 req", int'(req), 0);
        chk("R12 active", int'(burst_active), 0);
        chk("R12 count", int'(dw_count), 0);

        // R2 R3 R4 R5 R7 R9 sweep over class, direction and threshold code
        for (int a = 0; a < 2; a++) begin
            for (int d = 0; d < 2; d++) begin
                for (int t = 0; t < 4; t++) begin
                    int thr;
                    thr = exp_thr(a, t);
                    chan_audio = 1'(a); dir_rd = 1'(d);
                    set_avail(0);
                    cfg_write(0, t);
                    chk("R6 readback", int'(cfg_rdata), t);
                    set_avail(thr - 1);
                    tick(); tick();
                    chk(a ? "R3 R5 below audio" : "R2 R5 below video", int'(req), 0);
                    set_avail(thr);
                    tick();
                    chk(d ? "R4 R5 equal read" : "R4 R5 equal write", int'(req), 1);
                    chk("R1 code0 length", int'(burst_len), 1);
                    set_avail(0);
                    tick();
                    chk("R7 hold", int'(req), 1);
                    set_avail(thr);
                    grant = 1'b1;
                    tick();
                    grant = 1'b0;
                    chk("R7 req low", int'(req), 0);
                    chk("R7 active", int'(burst_active), 1);
                    chk("R8 load", int'(dw_count), 1);
                    set_avail(0);
                    tick();
                    chk("R9 starve end", int'(burst_active), 0);
                    chk("R9 starve clear", int'(dw_count), 0);
                end
            end
        end

        // R1 R8 full bursts for every burst code, drain mode, video
        chan_audio = 1'b0; dir_rd = 1'b0;
        for (int c = 0; c < 8; c++) begin
            int len;
            len = 1 << c;
            fifo_level = '0;
            cfg_write(c, 0);
            fifo_level = 7'(DEPTH);
            tick();
            chk("R1 length", int'(burst_len), len);
            grant = 1'b1;
            tick();
            grant = 1'b0;
            chk("R8 load", int'(dw_count), len);
            for (int i = 0; i < len; i++) begin
                dw_accept = ((i % 5) != 4) || (i == len - 1) ? 1'b1 : 1'b0;
                tick();
                if (dw_accept == 1'b0) begin
                    dw_accept = 1'b1;
                    chk("R8 idle cycle", int'(dw_count), len - i);
                    tick();
                end
                if (i < len - 1) chk("R8 count", int'(dw_count), len - 1 - i);
            end
            dw_accept = 1'b0;
            chk("R8 done active", int'(burst_active), 0);
            chk("R8 done count", int'(dw_count), 0);
            chk("R8 done req", int'(req), 0);
            fifo_level = '0;
        end

        // R10 configuration write in the middle of a burst
        cfg_write(2, 0);
        fifo_level = 7'(DEPTH);
        tick();
        grant = 1'b1;
        tick();
        grant = 1'b0;
        chk("R10 start", int'(dw_count), 4);
        cfg_write(7, 3);
        chk("R6 new codes", int'(cfg_rdata), (7 << 2) | 3);
        chk("R10 length kept", int'(burst_len), 4);
        chk("R10 count kept", int'(dw_count), 4);
        for (int i = 0; i < 4; i++) begin
            dw_accept = 1'b1;
            tick();
        end
        dw_accept = 1'b0;
        chk("R10 old burst ended", int'(burst_active), 0);
        tick();
        chk("R10 next req", int'(req), 1);
        chk("R10 next length", int'(burst_len), 128);
        grant = 1'b1;
        tick();
        grant = 1'b0;
        chk("R10 next load", int'(dw_count), 128);
        fifo_level = '0;
        tick();
        chk("R9 drain starve", int'(dw_count), 0);

        // R8 R9 last Dword and FIFO exhaustion in the same cycle
        cfg_write(1, 0);
        fifo_level = 7'(DEPTH);
        tick();
        grant = 1'b1;
        tick();
        grant = 1'b0;
        dw_accept = 1'b1;
        tick();
        chk("R8 collide pre", int'(dw_count), 1);
        fifo_level = '0;
        tick();
        dw_accept = 1'b0;
        chk("R9 collide active", int'(burst_active), 0);
        chk("R9 collide count", int'(dw_count), 0);
        tick();
        chk("R9 collide no rereq", int'(req), 0);
        chk("R12 idle count", int'(dw_count), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule